// File: doc/BRIEF.md
# Multi-Virtual-Channel Clock-Crossing Link

This block moves flits over a point-to-point link from a sender that runs on one clock to a receiver that runs on another, unrelated clock. Traffic is split into virtual channels. Each channel has its own small asynchronous FIFO, so one channel that stalls does not block the others. The sender presents a flit with a channel number and a valid strobe. In return it sees one full flag per channel. It must hold back a channel whose flag is raised.

On the receiving side the receiver raises a ready bit for each channel it can accept. Every channel that holds data and has its ready bit high competes for the single output. A round-robin arbiter chooses one of them in each read-clock cycle. It then starts its next search at the channel after the winner, so no requester waits forever. The flit that is shown is taken on the next read-clock edge. The number of channels, the flit width and the FIFO depth are parameters.

Top module: `vc_cdc_link`

## Requirements
- R1: While either reset is low, and right after both are released, `rd_valid` is 0 and every bit of `wr_full` is 0.
- R2: Flits written to channel v leave with `rd_vc` equal to v, in the order in which they were written. No flit is lost and none is repeated. This holds while writes and reads run at the same time on different clocks.
- R3: `wr_full[v]` is 1 in the write-clock cycle after the write that makes channel v hold `2**ADDR_W` flits. A write to a channel whose `wr_full` bit is 1 is dropped, and that flit never appears on the read port.
- R4: `rd_valid` is 1 only when `rd_ready[rd_vc]` is 1. A channel whose ready bit is low is never served.
- R5: Arbitration is round robin. After channel g is granted, the search starts at channel g+1 and wraps from `NUM_VC-1` to 0. Right after reset the search starts at channel 0. With every channel loaded and ready, grants come out in the order 0,1,...,`NUM_VC-1`,0,...
- R6: A channel can be granted in two consecutive read cycles only when it is the only channel that both holds data and is ready. Exactly one flit leaves on each read edge where `rd_valid` is 1.
- R7: After the receiver drains a full channel, `wr_full` for that channel returns to 0 within a few write-clock cycles. The two clocks may run at any ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Sender-side clock |
| wr_rst_n | input | 1 | Sender-side reset, active low |
| wr_valid | input | 1 | A flit is offered on the write port |
| wr_vc | input | $clog2(NUM_VC) | Channel the offered flit belongs to |
| wr_data | input | DATA_W | Offered flit |
| wr_full | output | NUM_VC | Per-channel full flag, in the write domain |
| rd_clk | input | 1 | Receiver-side clock |
| rd_rst_n | input | 1 | Receiver-side reset, active low |
| rd_ready | input | NUM_VC | Per-channel ready from the receiver |
| rd_valid | output | 1 | A flit is shown and is taken on the next read edge |
| rd_vc | output | $clog2(NUM_VC) | Channel of the shown flit |
| rd_data | output | DATA_W | Shown flit |

## Verification
Two things can happen on the same channel at once. The sender can push a flit into a FIFO while the receiver pops a flit from it, and the full and empty decisions then depend on pointers copied across the clock boundary. A random phase provokes this. The sender keeps all channels close to full, the receiver toggles its ready bits at random, and the two clocks run at an uneven ratio. Every flit that leaves is compared against per-channel queues in the bench, and every queue must be empty once the final drain is over.

// File: rtl/vc_cdc_link.sv
module vc_cdc_link #(
  parameter int NUM_VC = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  localparam int VC_W  = $clog2(NUM_VC),
  localparam int DEPTH = 1 << ADDR_W,
  localparam int PW    = ADDR_W + 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_valid,
  input  logic [VC_W-1:0]   wr_vc,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_VC-1:0] wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic [NUM_VC-1:0] rd_ready,
  output logic              rd_valid,
  output logic [VC_W-1:0]   rd_vc,
  output logic [DATA_W-1:0] rd_data
);
  logic [NUM_VC-1:0] empty, req;
  logic [DATA_W-1:0] head [NUM_VC];
  logic [VC_W-1:0]   gnt, ptr;

  for (genvar i = 0; i < NUM_VC; i++) begin : g_vc
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rq1, rq2;
    logic [PW-1:0] rbin, rgray, wq1, wq2;
    logic [PW-1:0] wbin_n, rbin_n;
    logic push, pop;

    assign wbin_n = wbin + 1'b1;
    assign rbin_n = rbin + 1'b1;
    assign wr_full[i] = (wgray == {~rq2[PW-1:PW-2], rq2[PW-3+1-1:0]});
    assign push = wr_valid && (wr_vc == VC_W'(i)) && !wr_full[i];
    assign empty[i] = (rgray == wq2);
    assign req[i] = !empty[i] && rd_ready[i];
    assign pop = rd_valid && (gnt == VC_W'(i));
    assign head[i] = mem[rbin[ADDR_W-1:0]];

    always_ff @(posedge wr_clk) if (push) mem[wbin[ADDR_W-1:0]] <= wr_data;

    always_ff @(posedge wr_clk or negedge wr_rst_n)
      if (!wr_rst_n) begin
        wbin <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0;
      end else begin
        rq1 <= rgray;
        rq2 <= rq1;
        if (push) begin
          wbin  <= wbin_n;
          wgray <= wbin_n ^ (wbin_n >> 1);
        end
      end

    always_ff @(posedge rd_clk or negedge rd_rst_n)
      if (!rd_rst_n) begin
        rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0;
      end else begin
        wq1 <= wgray;
        wq2 <= wq1;
        if (pop) begin
          rbin  <= rbin_n;
          rgray <= rbin_n ^ (rbin_n >> 1);
        end
      end
  end

  always_comb begin
    int idx;
    logic found;
    gnt = '0;
    found = 1'b0;
    for (int k = 0; k < NUM_VC; k++) begin
      idx = int'(ptr) + k;
      if (idx >= NUM_VC) idx = idx - NUM_VC;
      if (!found && req[idx]) begin
        found = 1'b1;
        gnt = VC_W'(idx);
      end
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) ptr <= '0;
    else if (rd_valid) ptr <= (gnt == VC_W'(NUM_VC - 1)) ? '0 : gnt + 1'b1;

  assign rd_valid = |req;
  assign rd_vc    = gnt;
  assign rd_data  = head[gnt];
endmodule

module vc_cdc_link_chk #(
  parameter int NUM_VC = 4,
  parameter int VC_W = 2
) (
  input logic              wr_clk,
  input logic              wr_rst_n,
  input logic [NUM_VC-1:0] wr_full,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic [NUM_VC-1:0] rd_ready,
  input logic [NUM_VC-1:0] empty,
  input logic              rd_valid,
  input logic [VC_W-1:0]   rd_vc
);
  always @(posedge rd_clk)
    if (!rd_rst_n) assert_idle_in_reset_R1: assert (!rd_valid);

  always @(posedge wr_clk)
    if (!wr_rst_n) assert_not_full_in_reset_R1: assert (wr_full == '0);

  assert_only_ready_served_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_valid |-> rd_ready[rd_vc]);

  assert_served_not_empty_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_valid |-> !empty[rd_vc]);

  assert_repeat_only_if_alone_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_valid && $past(rd_valid) && rd_vc == $past(rd_vc))
      |-> ($countones(rd_ready & ~empty) == 1));
endmodule

bind vc_cdc_link vc_cdc_link_chk #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_chk (.*);

// File: tb/test_vc_cdc_link.sv
module test_vc_cdc_link;
  localparam int NV = 4, DW = 16, AW = 2, VW = 2, DEPTH = 1 << AW;

  logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
  logic wr_valid = 0;
  logic [VW-1:0] wr_vc = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NV-1:0] wr_full, rd_ready = '0;
  logic rd_valid;
  logic [VW-1:0] rd_vc;
  logic [DW-1:0] rd_data;

  int total = 0, bad = 0;
  bit done = 0, rr_phase = 0;
  int rr_last = NV - 1;
  logic [DW-1:0] mq [NV][$];

  always #10 wr_clk = ~wr_clk;
  always #13 rd_clk = ~rd_clk;

  vc_cdc_link #(.NUM_VC(NV), .DATA_W(DW), .ADDR_W(AW)) i_vc_cdc_link (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge wr_clk)
    if (wr_rst_n && wr_valid && !wr_full[wr_vc]) mq[wr_vc].push_back(wr_data);

  always @(negedge rd_clk)
    if (rd_rst_n && rd_valid) begin
      check(rd_ready[rd_vc], "R4 served channel not ready", int'(rd_ready[rd_vc]), 1);
      if (mq[rd_vc].size() == 0)
        check(0, "R2 flit on empty channel", int'(rd_vc), -1);
      else begin
        check(rd_data == mq[rd_vc][0], "R2 data order", int'(rd_data), int'(mq[rd_vc][0]));
        void'(mq[rd_vc].pop_front());
      end
      if (rr_phase) check(int'(rd_vc) == (rr_last + 1) % NV, "R5 round robin order",
                          int'(rd_vc), (rr_last + 1) % NV);
      rr_last = int'(rd_vc);
    end

  task automatic put(input int v, input int d);
    wr_vc = VW'(v); wr_data = DW'(d); wr_valid = 1;
    @(posedge wr_clk); #1 wr_valid = 0;
  endtask

  function automatic int pending();
    int n = 0;
    for (int v = 0; v < NV; v++) n += mq[v].size();
    return n;
  endfunction

  task automatic drain_wait();
    for (int i = 0; i < 400 && pending() != 0; i++) @(posedge rd_clk);
    repeat (4) @(posedge rd_clk);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge wr_clk);
    @(negedge wr_clk);
    check(wr_full == '0, "R1 full in reset", int'(wr_full), 0);
    check(!rd_valid, "R1 valid in reset", int'(rd_valid), 0);
    #3 wr_rst_n = 1;
    #17 rd_rst_n = 1;
    repeat (3) @(posedge rd_clk);
    @(negedge rd_clk);
    check(!rd_valid, "R1 valid after reset", int'(rd_valid), 0);
    check(wr_full == '0, "R1 full after reset", int'(wr_full), 0);

    // R3 / R5: load every channel to the brim, then drain with all ready
    @(posedge wr_clk); #1;
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (k == DEPTH - 1) begin
          @(negedge wr_clk);
          check(!wr_full[v], "R3 full too early", int'(wr_full[v]), 0);
          @(posedge wr_clk); #1;
        end
        put(v, v * 256 + k);
      end
      @(negedge wr_clk);
      check(wr_full[v], "R3 full flag", int'(wr_full[v]), 1);
      @(posedge wr_clk); #1;
    end
    put(0, 16'hDEAD);
    repeat (12) @(posedge rd_clk);
    @(negedge rd_clk);
    check(!rd_valid, "R4 nothing served while no ready", int'(rd_valid), 0);
    rr_phase = 1;
    @(posedge rd_clk); #1 rd_ready = '1;
    drain_wait();
    rr_phase = 0;
    @(negedge rd_clk);
    check(pending() == 0, "R3 dropped write stayed out", pending(), 0);
    check(!rd_valid, "R3 no extra flit", int'(rd_valid), 0);
    repeat (8) @(posedge wr_clk);
    @(negedge wr_clk);
    check(wr_full == '0, "R7 full clears after drain", int'(wr_full), 0);

    // R4 / R6: only one channel ready; the other must keep its flits
    rd_ready = '0;
    @(posedge wr_clk); #1;
    for (int k = 0; k < 3; k++) put(1, 16'h1100 + k);
    for (int k = 0; k < 3; k++) put(2, 16'h2200 + k);
    repeat (8) @(posedge rd_clk); #1 rd_ready = 4'b0100;
    repeat (12) @(posedge rd_clk);
    @(negedge rd_clk);
    check(mq[2].size() == 0, "R6 sole requester drained back to back", mq[2].size(), 0);
    check(mq[1].size() == 3, "R4 unready channel untouched", mq[1].size(), 3);
    @(posedge rd_clk); #1 rd_ready = 4'b0010;
    drain_wait();
    @(negedge rd_clk);
    check(pending() == 0, "R4 channel drained once ready", pending(), 0);

    // R2 / R7: concurrent random traffic on both clocks
    fork
      begin
        for (int i = 0; i < 3000; i++) begin
          @(posedge wr_clk); #1;
          wr_vc = VW'($urandom_range(NV - 1));
          wr_data = DW'($urandom);
          wr_valid = !wr_full[wr_vc] && ($urandom_range(3) != 0);
        end
        @(posedge wr_clk); #1 wr_valid = 0;
      end
      begin
        for (int i = 0; i < 2400; i++) begin
          @(posedge rd_clk); #1 rd_ready = NV'($urandom);
        end
      end
    join
    @(posedge rd_clk); #1 rd_ready = '1;
    drain_wait();
    @(negedge rd_clk);
    check(pending() == 0, "R2 all random flits delivered", pending(), 0);
    check(!rd_valid, "R2 nothing left after drain", int'(rd_valid), 0);
    repeat (8) @(posedge wr_clk);
    @(negedge wr_clk);
    check(wr_full == '0, "R7 full clear after random run", int'(wr_full), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule